// File: doc/BRIEF.md
# Unsigned Fixed-Point to Floating-Point Converter

This block turns an unsigned integer operand, read as a fixed-point number with a selectable count of fraction bits, into an IEEE 754 binary16, binary32 or binary64 value. The operand is 32 or 64 bits wide. The number of fraction bits is carried in a 6-bit scale field as 64 minus the scale, so a scale of zero means 64 fraction bits. One normalise, round and pack datapath serves all three output formats. Rounding follows a 2-bit mode input. Inexact and overflow results are reported as status flags.

The result is placed in the low end of a 128-bit destination. With merge enabled, the bits above the result come from the old destination value supplied on the input. With merge disabled, those bits are cleared. Illegal encodings raise an undefined-encoding flag and write nothing. The block has a single register stage, so each accepted request produces its result on the next clock cycle.

Top module: `ufx2f_conv`

## Requirements
- R1: With `src_wide`=0 only `operand[31:0]` is converted and `operand[63:32]` has no effect on the result. With `src_wide`=1 all 64 bits are converted.
- R2: Format code 00 selects binary32, 01 selects binary64 and 11 selects binary16. Code 10 raises `out_undef`, sets `dst` equal to the old destination unchanged (whatever the merge setting) and clears both status flags.
- R3: The fraction-bit count is 64 minus the unsigned scale value, so a scale of 0 gives 64. A 32-bit source whose `scale[5]` is 0 is illegal and is handled the same way as format code 10.
- R4: The operand is always unsigned. An operand with its top bit set gives a large positive result, and the sign bit of the result is always 0.
- R5: Rounding mode 00 rounds to nearest with ties to even, 01 rounds toward +infinity and 11 rounds toward zero.
- R6: Rounding mode 10 (toward -infinity) gives exactly the same results as mode 11.
- R7: A zero operand gives +0.0 with both flags clear.
- R8: `out_inexact` is set whenever the rounded result differs from the exact value. This includes a round-up that carries into the exponent.
- R9: A binary16 result whose rounded magnitude exceeds 65504 sets `out_overflow` and `out_inexact`. It returns 0x7C00 in modes 00 and 01, and 0x7BFF in modes 10 and 11. A value that rounds down to 65504 does not overflow. Only binary16 can overflow.
- R10: A binary16 result below 2^-14 is encoded as a subnormal and rounded at the 2^-24 step. It can round to 0 (inexact) or up to a subnormal code.
- R11: With `merge_en`=1, `dst` bits above the result width (16, 32 or 64) keep `old_dst`. With `merge_en`=0 those bits are 0.
- R12: `out_valid` and the result appear one clock after `in_valid`. When `in_valid` is low, `out_valid` falls and `dst` and the flags hold their value. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_wide | input | 1 | 0: 32-bit source, 1: 64-bit source |
| fmt_code | input | 2 | Output format code |
| scale | input | 6 | Scale field (fraction bits = 64 - scale) |
| rnd_mode | input | 2 | Rounding mode |
| merge_en | input | 1 | Keep upper bits of the old destination |
| old_dst | input | 128 | Previous destination value |
| operand | input | 64 | Unsigned fixed-point operand |
| out_valid | output | 1 | Result valid |
| dst | output | 128 | New destination value |
| out_undef | output | 1 | Illegal encoding |
| out_inexact | output | 1 | Result was rounded |
| out_overflow | output | 1 | Result exceeded the format's range |

## Verification
The hardest cases to reach are the binary16 edges: a subnormal tie, and values just below and just above the overflow threshold. These depend on the operand, the scale and the rounding mode all together. The stimulus uses very large scales so that a tiny operand lands below 2^-14, and a scale of 63 so that operands near 131040 sit on either side of 65504. Each of these operands is then replayed under several rounding modes. Rounding ties are produced with operands whose first dropped bit is exactly one half.

// File: rtl/ufx2f_pkg.sv
package ufx2f_pkg;
    localparam int OP_W     = 64;
    localparam int NARROW_W = 32;
    localparam int DST_W    = 128;
    localparam int SCALE_W  = 6;
    localparam int LZ_W     = $clog2(OP_W) + 1;
    localparam int EXP_W    = 12;
    localparam int SIG_W    = 53;
    localparam int HALF_W   = 16;
    localparam int SNGL_W   = 32;
    localparam int DBL_W    = 64;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_BAD    = 2'b10,
        FMT_HALF   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rm_e;

    typedef struct packed {
        logic [5:0]  man_w;
        logic [10:0] bias;
        logic [10:0] exp_ones;
    } fmt_info_t;

    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] dst;
        logic             undef;
        logic             inexact;
        logic             overflow;
    } out_st_t;
endpackage

// File: rtl/ufx2f_decode.sv
module ufx2f_decode
    import ufx2f_pkg::*;
(
    input  logic               src_wide,
    input  logic [1:0]         fmt_code,
    input  logic [SCALE_W-1:0] scale,
    output logic               undef,
    output fmt_e               fmt,
    output logic [LZ_W-1:0]    frac_bits,
    output fmt_info_t          info
);
    always_comb begin
        fmt       = fmt_e'(fmt_code);
        undef     = (fmt_code == 2'b10) || (!src_wide && !scale[SCALE_W-1]);
        frac_bits = LZ_W'(OP_W) - {1'b0, scale};
        case (fmt_code)
            2'b11:   info = '{man_w: 6'd10, bias: 11'd15,   exp_ones: 11'd31};
            2'b01:   info = '{man_w: 6'd52, bias: 11'd1023, exp_ones: 11'd2047};
            default: info = '{man_w: 6'd23, bias: 11'd127,  exp_ones: 11'd255};
        endcase
    end
endmodule

// File: rtl/ufx2f_lzc.sv
module ufx2f_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/ufx2f_round.sv
module ufx2f_round
    import ufx2f_pkg::*;
(
    input  logic [OP_W-1:0] mag,
    input  logic [LZ_W-1:0] lz,
    input  logic [LZ_W-1:0] frac_bits,
    input  fmt_info_t       info,
    input  rm_e             rmode,
    output logic [OP_W-1:0] packed_o,
    output logic            inexact_o,
    output logic            overflow_o
);
    localparam int WIDE_W = 3 * OP_W;
    localparam int SIG_LO = WIDE_W - SIG_W;

    logic signed [EXP_W-1:0] e_unb, e_min, e_bm1, d_sub;
    logic                    sub;
    logic [7:0]              sh;
    logic [OP_W-1:0]         norm;
    logic [WIDE_W-1:0]       wide;
    logic [SIG_W-1:0]        sig;
    logic                    guard, sticky, inc;
    logic [OP_W-1:0]         sum, base, raw, expf, inf_v, max_fin;
    logic                    ovf;

    always_comb begin
        // unbiased exponent of the leading one
        e_unb = $signed(EXP_W'(OP_W - 1)) - $signed(EXP_W'(lz)) - $signed(EXP_W'(frac_bits));
        e_min = $signed(EXP_W'(1)) - $signed({1'b0, info.bias});
        sub   = e_unb < e_min;
        d_sub = sub ? (e_min - e_unb) : '0;
        // align so the kept significand always sits in the top SIG_W bits
        sh    = d_sub[7:0] + 8'(SIG_W - 1) - {2'b0, info.man_w};
        norm  = mag << lz;
        wide  = {norm, {(WIDE_W - OP_W){1'b0}}} >> sh;
        sig    = wide[WIDE_W-1 -: SIG_W];
        guard  = wide[SIG_LO-1];
        sticky = |wide[SIG_LO-2:0];
        case (rmode)
            RM_NEAR: inc = guard & (sticky | sig[0]);
            RM_UP:   inc = guard | sticky;
            default: inc = 1'b0;
        endcase
        sum   = OP_W'(sig) + OP_W'(inc);
        e_bm1 = e_unb + $signed({1'b0, info.bias}) - $signed(EXP_W'(1));
        base  = sub ? '0 : OP_W'($unsigned(e_bm1));
        // hidden bit and any carry-out add into the exponent field
        raw     = (base << info.man_w) + sum;
        expf    = raw >> info.man_w;
        ovf     = expf >= OP_W'(info.exp_ones);
        inf_v   = OP_W'(info.exp_ones) << info.man_w;
        max_fin = inf_v - OP_W'(1);
        if (mag == '0) begin
            packed_o   = '0;
            inexact_o  = 1'b0;
            overflow_o = 1'b0;
        end else if (ovf) begin
            packed_o   = (rmode == RM_NEAR || rmode == RM_UP) ? inf_v : max_fin;
            inexact_o  = 1'b1;
            overflow_o = 1'b1;
        end else begin
            packed_o   = raw;
            inexact_o  = guard | sticky;
            overflow_o = 1'b0;
        end
    end
endmodule

// File: rtl/ufx2f_conv.sv
module ufx2f_conv
    import ufx2f_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               src_wide,
    input  logic [1:0]         fmt_code,
    input  logic [SCALE_W-1:0] scale,
    input  logic [1:0]         rnd_mode,
    input  logic               merge_en,
    input  logic [DST_W-1:0]   old_dst,
    input  logic [OP_W-1:0]    operand,
    output logic               out_valid,
    output logic [DST_W-1:0]   dst,
    output logic               out_undef,
    output logic               out_inexact,
    output logic               out_overflow
);
    logic            undef_c;
    fmt_e            fmt_c;
    logic [LZ_W-1:0] frac_c, lz_c;
    fmt_info_t       info_c;
    logic [OP_W-1:0] mag_c, packed_c;
    logic            inexact_c, overflow_c;
    out_st_t         st_d, st_q;

    assign mag_c = src_wide ? operand : {{(OP_W - NARROW_W){1'b0}}, operand[NARROW_W-1:0]};

    ufx2f_decode u_dec (
        .src_wide  (src_wide),
        .fmt_code  (fmt_code),
        .scale     (scale),
        .undef     (undef_c),
        .fmt       (fmt_c),
        .frac_bits (frac_c),
        .info      (info_c)
    );

    ufx2f_lzc #(.W(OP_W), .CW(LZ_W)) u_lzc (
        .vec (mag_c),
        .cnt (lz_c)
    );

    ufx2f_round u_rnd (
        .mag        (mag_c),
        .lz         (lz_c),
        .frac_bits  (frac_c),
        .info       (info_c),
        .rmode      (rm_e'(rnd_mode)),
        .packed_o   (packed_c),
        .inexact_o  (inexact_c),
        .overflow_o (overflow_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (undef_c) begin
                st_d.dst      = old_dst;
                st_d.undef    = 1'b1;
                st_d.inexact  = 1'b0;
                st_d.overflow = 1'b0;
            end else begin
                st_d.dst = merge_en ? old_dst : '0;
                case (fmt_c)
                    FMT_HALF:   st_d.dst[HALF_W-1:0] = packed_c[HALF_W-1:0];
                    FMT_DOUBLE: st_d.dst[DBL_W-1:0]  = packed_c[DBL_W-1:0];
                    default:    st_d.dst[SNGL_W-1:0] = packed_c[SNGL_W-1:0];
                endcase
                st_d.undef    = 1'b0;
                st_d.inexact  = inexact_c;
                st_d.overflow = overflow_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign dst          = st_q.dst;
    assign out_undef    = st_q.undef;
    assign out_inexact  = st_q.inexact;
    assign out_overflow = st_q.overflow;
endmodule

// File: rtl/ufx2f_conv_chk.sv
module ufx2f_conv_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         src_wide,
    input logic [1:0]   fmt_code,
    input logic [5:0]   scale,
    input logic         merge_en,
    input logic [127:0] old_dst,
    input logic [63:0]  operand,
    input logic         out_valid,
    input logic [127:0] dst,
    input logic         out_undef,
    input logic         out_inexact,
    input logic         out_overflow
);
    logic legal, op_zero;
    assign legal   = (fmt_code != 2'b10) && (src_wide || scale[5]);
    assign op_zero = src_wide ? (operand == 64'd0) : (operand[31:0] == 32'd0);

    AST_UNDEF_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt_code == 2'b10 |=> out_undef && dst == $past(old_dst)); // R2
    AST_UNDEF_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !src_wide && !scale[5] |=> out_undef && dst == $past(old_dst)); // R3
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> !out_inexact && !out_overflow); // R2
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && op_zero && !merge_en |=> dst == 128'd0 && !out_inexact); // R7
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_overflow |-> out_inexact); // R9
    AST_OVF_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt_code != 2'b11 |=> !out_overflow); // R9
    AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && merge_en && fmt_code == 2'b01 |=> dst[127:64] == $past(old_dst[127:64])); // R11
    AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && !merge_en && fmt_code == 2'b11 |=> dst[127:16] == 112'd0); // R11
    AST_HALF_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal && fmt_code == 2'b11 |=> !dst[15]); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(dst)); // R12
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12
endmodule

bind ufx2f_conv ufx2f_conv_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_wide     (src_wide),
    .fmt_code     (fmt_code),
    .scale        (scale),
    .merge_en     (merge_en),
    .old_dst      (old_dst),
    .operand      (operand),
    .out_valid    (out_valid),
    .dst          (dst),
    .out_undef    (out_undef),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow)
);

// File: tb/ufx2f_conv_test.sv
module ufx2f_conv_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         src_wide = 1'b0;
    logic [1:0]   fmt_code = 2'b00;
    logic [5:0]   scale = 6'd63;
    logic [1:0]   rnd_mode = 2'b00;
    logic         merge_en = 1'b0;
    logic [127:0] old_dst = '0;
    logic [63:0]  operand = '0;
    logic         out_valid;
    logic [127:0] dst;
    logic         out_undef, out_inexact, out_overflow;

    localparam logic [127:0] OLD = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEED_FACE;
    localparam logic [1:0] S = 2'b00, D = 2'b01, B = 2'b10, H = 2'b11;
    localparam logic [1:0] NE = 2'b00, UP = 2'b01, DN = 2'b10, TZ = 2'b11;

    typedef struct {
        logic [127:0] dst;
        logic         undef;
        logic         inx;
        logic         ovf;
        string        req;
    } item_t;

    item_t        sb[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    logic [127:0] last_dst = '0;
    bit           done = 0;

    always #2 clk = ~clk;

    ufx2f_conv uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .src_wide (src_wide),
        .fmt_code (fmt_code), .scale (scale), .rnd_mode (rnd_mode), .merge_en (merge_en),
        .old_dst (old_dst), .operand (operand), .out_valid (out_valid), .dst (dst),
        .out_undef (out_undef), .out_inexact (out_inexact), .out_overflow (out_overflow)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic send(input logic w, input logic [1:0] f, input logic [5:0] sc,
                        input logic [1:0] rm, input logic mg, input logic [63:0] op,
                        input logic [127:0] e_dst, input logic e_undef, input logic e_inx,
                        input logic e_ovf, input string req);
        item_t it;
        @(negedge clk);
        src_wide = w; fmt_code = f; scale = sc; rnd_mode = rm; merge_en = mg;
        old_dst = OLD; operand = op; in_valid = 1'b1;
        it.dst = e_dst; it.undef = e_undef; it.inx = e_inx; it.ovf = e_ovf; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R12: result with nothing expected, got %h exp none", dst);
            end else begin
                item_t it;
                it = sb.pop_front();
                last_dst = it.dst;
                if ({dst, out_undef, out_inexact, out_overflow} !== {it.dst, it.undef, it.inx, it.ovf}) begin
                    n_bad++;
                    $display("FAIL %s: got dst=%h u=%b i=%b o=%b exp dst=%h u=%b i=%b o=%b",
                             it.req, dst, out_undef, out_inexact, out_overflow,
                             it.dst, it.undef, it.inx, it.ovf);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++; // R12 reset state
        if ({out_valid, dst, out_undef, out_inexact, out_overflow} !== '0) begin
            n_bad++;
            $display("FAIL R12: reset got dst=%h v=%b exp all zero", dst, out_valid);
        end
        rst_n = 1'b1;
        send(1, S, 63, NE, 0, 64'd0, 128'd0, 0, 0, 0, "R7");
        send(0, S, 63, NE, 0, 64'd6, 128'h4040_0000, 0, 0, 0, "R3");
        send(0, S, 32, NE, 0, 64'h8000_0000, 128'h3F00_0000, 0, 0, 0, "R3");
        send(1, D, 0, NE, 0, 64'h8000_0000_0000_0000, 128'h3FE0_0000_0000_0000, 0, 0, 0, "R3");
        send(0, S, 31, NE, 0, 64'd6, OLD, 1, 0, 0, "R3");
        send(1, B, 63, NE, 1, 64'd6, OLD, 1, 0, 0, "R2");
        send(0, S, 63, NE, 0, 64'hFFFF_FFFF_0000_0005, 128'h4020_0000, 0, 0, 0, "R1");
        send(1, D, 63, NE, 0, '1, 128'h43E0_0000_0000_0000, 0, 1, 0, "R4");
        send(1, D, 63, TZ, 0, '1, 128'h43DF_FFFF_FFFF_FFFF, 0, 1, 0, "R5");
        send(1, D, 63, DN, 0, '1, 128'h43DF_FFFF_FFFF_FFFF, 0, 1, 0, "R6");
        send(0, H, 63, NE, 0, 64'h1002, 128'h6800, 0, 1, 0, "R5");
        send(0, H, 63, UP, 0, 64'h1002, 128'h6801, 0, 1, 0, "R5");
        send(0, H, 63, NE, 0, 64'h1006, 128'h6802, 0, 1, 0, "R5");
        send(1, H, 63, NE, 0, 64'h1FFDE, 128'h7BFF, 0, 1, 0, "R9");
        send(1, H, 63, UP, 0, 64'h1FFDE, 128'h7C00, 0, 1, 1, "R9");
        send(1, H, 63, NE, 0, 64'h20000, 128'h7C00, 0, 1, 1, "R9");
        send(1, H, 63, TZ, 0, 64'h20000, 128'h7BFF, 0, 1, 1, "R9");
        send(1, H, 63, DN, 0, 64'h20000, 128'h7BFF, 0, 1, 1, "R6");
        send(0, H, 40, NE, 0, 64'd1, 128'h0001, 0, 0, 0, "R10");
        send(1, H, 0, NE, 0, 64'd1, 128'h0000, 0, 1, 0, "R10");
        send(1, H, 0, UP, 0, 64'd1, 128'h0001, 0, 1, 0, "R10");
        send(0, H, 39, NE, 0, 64'd3, 128'h0002, 0, 1, 0, "R10");
        send(0, S, 32, NE, 0, 64'hFFFF_FFFF, 128'h3F80_0000, 0, 1, 0, "R8");
        send(1, D, 0, NE, 0, 64'h8000_0000_0000_0001, 128'h3FE0_0000_0000_0000, 0, 1, 0, "R8");
        send(0, S, 63, NE, 1, 64'd6, {OLD[127:32], 32'h4040_0000}, 0, 0, 0, "R11");
        send(0, H, 63, NE, 0, 64'd2, 128'h3C00, 0, 0, 0, "R11");
        send(0, D, 63, NE, 1, 64'd6, {OLD[127:64], 64'h4008_0000_0000_0000}, 0, 0, 0, "R11");
        send(0, H, 63, TZ, 1, 64'd2, {OLD[127:16], 16'h3C00}, 0, 0, 0, "R11");
        @(negedge clk);
        in_valid = 1'b0;
        operand = 64'h1234;
        repeat (3) @(negedge clk);
        n_cmp++; // R12 idle hold
        if (out_valid !== 1'b0 || dst !== last_dst || sb.size() != 0) begin
            n_bad++;
            $display("FAIL R12: idle got v=%b dst=%h pending=%0d exp v=0 dst=%h pending=0",
                     out_valid, dst, sb.size(), last_dst);
        end
        report();
    end
endmodule